// File: doc/BRIEF.md
# LCD Status Interrupt Generator

This block keeps the display's dot and line position, works out which of the four display phases the current dot falls in, and keeps the line-compare match flag. The four phases are horizontal blank, vertical blank, object search and pixel transfer. It combines the phase conditions and the match flag, each gated by its own enable bit, into one shared request line. It sends a one-cycle interrupt pulse only when that shared line goes from low to high. Software writes the enable bits through a status register and the compare value through a compare register. It reads back a status byte that carries the enables, the match flag and the phase.

Because the request line is shared, a source that is already holding it high hides a new source that turns on. For example, a vertical-blank condition that runs into line 0 hides that line's object-search request. Some timing details follow the display hardware:

- On the first vertical-blank line, an object-search condition is raised together with the vertical-blank one.
- A new compare value reaches the comparator only after a fixed delay.
- Changes to the vertical-blank and line-compare enables reach the request line late.
- The first line after the display is switched on has a longer pixel-transfer phase.
- While the display is off, the match flag holds its last value. Enabling the compare source at that time can still raise a request.

Top module: `lcd_stat_irq`

## Requirements
- R1: A line lasts LINE_DOTS dots, 0 to LINE_DOTS-1. The line counter on `line_rd` counts 0 to FRAME_LINES-1 and then wraps to 0.
- R2: On lines below VBLANK_LINE the phase codes on status bits 1:0 are as follows. Dots below OAM_DOTS read 2. The next XFER_DOTS dots read 3; on the first line after the display is switched on this is XFER_DOTS+FIRST_EXTRA dots. The remaining dots read 0. Lines from VBLANK_LINE upward read 1.
- R3: The shared line is the OR of four terms: phase 0 with status bit 3, phase 1 with bit 4, the object-search condition with bit 5, and the match flag with bit 6. `irq_pulse` is high for one cycle, one cycle after the shared line rises. There is no pulse while the line stays high.
- R4: The object-search condition is true during dots below OAM_DOTS on every line up to and including VBLANK_LINE. With only bit 5 set, a frame therefore gives VBLANK_LINE+1 pulses.
- R5: A value written to the compare register reaches the comparator LYC_LAT cycles after the write.
- R6: Status bit 2 is the match flag, which is line == compare value while the display is on. It keeps its last value while the display is off.
- R7: A status write that enables a source whose condition is already true raises a request. For bit 3 or bit 5 the pulse appears in the second cycle after the write. This also holds for bit 6 while the display is off and the held flag is 1.
- R8: Changes to bits 4 and 6 reach the shared line EN_LAT cycles later than changes to bits 3 and 5. With the held flag at 1, enabling bit 6 gives its pulse EN_LAT+2 cycles after the write.
- R9: The status byte has bit 7 = 1, bits 6:3 = the written enables, bit 2 = the match flag and bits 1:0 = the phase.
- R10: While `lcd_on` is low the phase reads 0, and from the next cycle `line_rd` is 0. The phase terms cannot raise a request.
- R11: After reset the status byte is 8'h80, `line_rd` is 0 and `irq_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_on | input | 1 | Display enable; low holds the counters at line 0, dot 0 |
| wr_stat | input | 1 | Write strobe for the status enables (bits 6:3 of `wr_data`) |
| wr_lyc | input | 1 | Write strobe for the compare register |
| wr_data | input | 8 | Write data shared by both registers |
| irq_pulse | output | 1 | One-cycle interrupt request |
| stat_rd | output | 8 | Status byte |
| line_rd | output | 8 | Current line counter |

## Verification
The in-RTL assertions check these rules on every cycle:
- the counters stay in range;
- vertical blank is only entered at dot 0 of VBLANK_LINE;
- the request is a single-cycle pulse and never follows a line that was already high;
- the match flag is frozen while the display is off;
- a switched-off display shows phase 0 and line 0;
- the object-search pulse at the start of VBLANK_LINE appears whenever the line was low.

Only the bench scenarios can show the whole-frame results. These are the pulse counts per frame, including the hidden object-search request on line 0, and the longer transfer phase on the first line. They also cover the exact cycle at which a delayed compare value or a delayed enable takes effect, and a request raised from the held flag while the display is off.

// File: rtl/stat_pkg.sv
package stat_pkg;

  typedef enum logic [1:0] {
    MD_HBLANK = 2'd0,
    MD_VBLANK = 2'd1,
    MD_SEARCH = 2'd2,
    MD_XFER   = 2'd3
  } stat_mode_t;

  // Enable bits as they sit in bits 6:3 of the status byte.
  typedef struct packed {
    logic lyc;
    logic m2;
    logic m1;
    logic m0;
  } stat_en_t;

  // Phase of a dot; the first line after enable has a longer transfer phase.
  function automatic stat_mode_t mode_calc(
    input logic [31:0] dot,
    input logic [31:0] line,
    input logic        first,
    input int unsigned oam,
    input int unsigned xfer,
    input int unsigned extra,
    input int unsigned vstart
  );
    int unsigned xfer_end;
    xfer_end = oam + xfer + (first ? extra : 0);
    if (line >= vstart)        return MD_VBLANK;
    else if (dot < oam)        return MD_SEARCH;
    else if (dot < xfer_end)   return MD_XFER;
    else                       return MD_HBLANK;
  endfunction

endpackage

// File: rtl/stat_delay.sv
module stat_delay #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/stat_timing.sv
module stat_timing
  import stat_pkg::*;
#(
  parameter int unsigned LINE_DOTS   = 456,
  parameter int unsigned FRAME_LINES = 154,
  parameter int unsigned VBLANK_LINE = 144,
  parameter int unsigned OAM_DOTS    = 80,
  parameter int unsigned XFER_DOTS   = 172,
  parameter int unsigned FIRST_EXTRA = 2,
  parameter int unsigned DOT_W       = 9,
  parameter int unsigned LINE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcd_on,
  output logic [DOT_W-1:0]  dot_q,
  output logic [LINE_W-1:0] line_q,
  output stat_mode_t        mode
);

  logic first_q;
  logic line_end;
  logic frame_end;
  logic in_vblank;

  assign line_end  = (32'(dot_q) == LINE_DOTS - 1);
  assign frame_end = (32'(line_q) == FRAME_LINES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q   <= '0;
      line_q  <= '0;
      first_q <= 1'b1;
    end else if (!lcd_on) begin
      dot_q   <= '0;
      line_q  <= '0;
      first_q <= 1'b1;
    end else if (line_end) begin
      dot_q   <= '0;
      first_q <= 1'b0;
      line_q  <= frame_end ? '0 : line_q + 1'b1;
    end else begin
      dot_q <= dot_q + 1'b1;
    end
  end

  assign mode = lcd_on ? mode_calc(32'(dot_q), 32'(line_q), first_q, OAM_DOTS,
                                   XFER_DOTS, FIRST_EXTRA, VBLANK_LINE)
                       : MD_HBLANK;
  assign in_vblank = (mode == MD_VBLANK);

  assert_counter_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(dot_q) < LINE_DOTS) && (32'(line_q) < FRAME_LINES));

  assert_vblank_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_vblank) |-> (32'(line_q) == VBLANK_LINE) && (dot_q == '0));

endmodule

// File: rtl/stat_lyc.sv
module stat_lyc #(
  parameter int unsigned LINE_W  = 8,
  parameter int unsigned LYC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcd_on,
  input  logic              wr_lyc,
  input  logic [7:0]        wr_data,
  input  logic [LINE_W-1:0] line_q,
  output logic              coin
);

  logic [7:0] lyc_q;
  logic [7:0] lyc_eff;
  logic       hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lyc_q <= '0;
    else if (wr_lyc) lyc_q <= wr_data;
  end

  stat_delay #(.W(8), .DEPTH(LYC_LAT)) u_lyc_lag (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (lyc_q),
    .q    (lyc_eff)
  );

  assign coin = lcd_on ? (8'(line_q) == lyc_eff) : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= coin;
  end

  assert_flag_frozen_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_on && $past(!lcd_on)) |-> $stable(coin));

endmodule

// File: rtl/stat_irq.sv
module stat_irq
  import stat_pkg::*;
#(
  parameter int unsigned OAM_DOTS    = 80,
  parameter int unsigned VBLANK_LINE = 144,
  parameter int unsigned EN_LAT      = 1,
  parameter int unsigned DOT_W       = 9,
  parameter int unsigned LINE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcd_on,
  input  logic              wr_stat,
  input  logic [7:0]        wr_data,
  input  stat_mode_t        mode,
  input  logic [DOT_W-1:0]  dot_q,
  input  logic [LINE_W-1:0] line_q,
  input  logic              coin,
  output stat_en_t          en_q,
  output logic              sig,
  output logic              sig_prev,
  output logic              irq_q
);

  logic [1:0] late_en;
  logic       c_m0, c_m1, c_m2, c_lyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_stat) en_q <= stat_en_t'(wr_data[6:3]);
  end

  // Vertical-blank and compare enables take effect late.
  stat_delay #(.W(2), .DEPTH(EN_LAT)) u_en_lag (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({en_q.m1, en_q.lyc}),
    .q    (late_en)
  );

  assign c_m0  = lcd_on && (mode == MD_HBLANK) && en_q.m0;
  assign c_m1  = lcd_on && (mode == MD_VBLANK) && late_en[1];
  assign c_m2  = lcd_on && en_q.m2 && (32'(dot_q) < OAM_DOTS)
                        && (32'(line_q) <= VBLANK_LINE);
  assign c_lyc = coin && late_en[0];
  assign sig   = c_m0 | c_m1 | c_m2 | c_lyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_prev <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      sig_prev <= sig;
      irq_q    <= sig && !sig_prev;
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_no_pulse_when_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sig && sig_prev) |=> !irq_q);

endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
  import stat_pkg::*;
#(
  parameter int unsigned LINE_DOTS   = 456,
  parameter int unsigned FRAME_LINES = 154,
  parameter int unsigned VBLANK_LINE = 144,
  parameter int unsigned OAM_DOTS    = 80,
  parameter int unsigned XFER_DOTS   = 172,
  parameter int unsigned FIRST_EXTRA = 2,
  parameter int unsigned LYC_LAT     = 2,
  parameter int unsigned EN_LAT      = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lcd_on,
  input  logic       wr_stat,
  input  logic       wr_lyc,
  input  logic [7:0] wr_data,
  output logic       irq_pulse,
  output logic [7:0] stat_rd,
  output logic [7:0] line_rd
);

  localparam int unsigned DOT_W  = $clog2(LINE_DOTS);
  localparam int unsigned LINE_W = $clog2(FRAME_LINES);

  logic [DOT_W-1:0]  dot_w;
  logic [LINE_W-1:0] line_w;
  stat_mode_t        mode_w;
  logic              coin_w;
  stat_en_t          en_w;
  logic              sig_w;
  logic              sig_prev_w;

  stat_timing #(
    .LINE_DOTS(LINE_DOTS), .FRAME_LINES(FRAME_LINES), .VBLANK_LINE(VBLANK_LINE),
    .OAM_DOTS(OAM_DOTS), .XFER_DOTS(XFER_DOTS), .FIRST_EXTRA(FIRST_EXTRA),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_timing (
    .clk   (clk),
    .rst_n (rst_n),
    .lcd_on(lcd_on),
    .dot_q (dot_w),
    .line_q(line_w),
    .mode  (mode_w)
  );

  stat_lyc #(.LINE_W(LINE_W), .LYC_LAT(LYC_LAT)) u_lyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .lcd_on (lcd_on),
    .wr_lyc (wr_lyc),
    .wr_data(wr_data),
    .line_q (line_w),
    .coin   (coin_w)
  );

  stat_irq #(
    .OAM_DOTS(OAM_DOTS), .VBLANK_LINE(VBLANK_LINE), .EN_LAT(EN_LAT),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lcd_on  (lcd_on),
    .wr_stat (wr_stat),
    .wr_data (wr_data),
    .mode    (mode_w),
    .dot_q   (dot_w),
    .line_q  (line_w),
    .coin    (coin_w),
    .en_q    (en_w),
    .sig     (sig_w),
    .sig_prev(sig_prev_w),
    .irq_q   (irq_pulse)
  );

  assign stat_rd = {1'b1, en_w, coin_w, mode_w};
  assign line_rd = 8'(line_w);

  assert_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |-> (stat_rd[1:0] == 2'd0) ##1 (line_rd == 8'd0));

  assert_vblank_search_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && 32'(line_w) == VBLANK_LINE && dot_w == '0 && en_w.m2 && !sig_prev_w)
      |=> irq_pulse);

endmodule

// File: tb/lcd_stat_irq_tb_top.sv
module lcd_stat_irq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE     = 3;
  localparam int DOTS  = 60;
  localparam int LINES = 16;
  localparam int VST   = 10;
  localparam int OAM   = 12;
  localparam int XFER  = 20;
  localparam int EXTRA = 2;
  localparam int LLAT  = 2;
  localparam int ELAT  = 1;
  localparam int FRAME = DOTS * LINES;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lcd_on = 1'b0;
  logic       wr_stat = 1'b0;
  logic       wr_lyc = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_pulse;
  logic [7:0] stat_rd;
  logic [7:0] line_rd;

  int compared = 0;
  int mismatched = 0;
  bit run_cmp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_stat_irq #(
    .LINE_DOTS(DOTS), .FRAME_LINES(LINES), .VBLANK_LINE(VST), .OAM_DOTS(OAM),
    .XFER_DOTS(XFER), .FIRST_EXTRA(EXTRA), .LYC_LAT(LLAT), .EN_LAT(ELAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .wr_stat(wr_stat),
    .wr_lyc(wr_lyc), .wr_data(wr_data), .irq_pulse(irq_pulse),
    .stat_rd(stat_rd), .line_rd(line_rd)
  );

  // Behavioural reference model
  int         m_dot, m_line;
  bit         m_first, m_hold, m_prev, m_irq;
  logic [7:0] m_lyc;
  logic [3:0] m_en;   // {lyc, m2, m1, m0}
  logic [7:0] lycq [$];
  logic [1:0] enq  [$];

  function automatic int exp_mode();
    if (!lcd_on) return 0;
    if (m_line >= VST) return 1;
    if (m_dot < OAM) return 2;
    if (m_dot < OAM + XFER + (m_first ? EXTRA : 0)) return 3;
    return 0;
  endfunction

  function automatic bit exp_coin();
    if (lcd_on) return (m_line == int'(lycq[0]));
    return m_hold;
  endfunction

  always @(posedge clk) begin
    int md;
    bit cn, sg;
    logic [1:0] lt;
    if (!rst_n) begin
      m_dot = 0; m_line = 0; m_first = 1; m_hold = 0; m_prev = 0; m_irq = 0;
      m_lyc = 0; m_en = 0;
      lycq.delete(); enq.delete();
      repeat (LLAT) lycq.push_back(8'h00);
      repeat (ELAT) enq.push_back(2'b00);
    end else begin
      md = exp_mode(); cn = exp_coin(); lt = enq[0];
      sg = (lcd_on && md == 0 && m_en[0]) || (lcd_on && md == 1 && lt[1]) ||
           (lcd_on && m_en[2] && m_dot < OAM && m_line <= VST) || (cn && lt[0]);
      m_irq = sg && !m_prev;
      m_prev = sg;
      m_hold = cn;
      lycq.push_back(m_lyc); void'(lycq.pop_front());
      enq.push_back({m_en[1], m_en[3]}); void'(enq.pop_front());
      if (wr_lyc)  m_lyc = wr_data;
      if (wr_stat) m_en = wr_data[6:3];
      if (!lcd_on) begin
        m_dot = 0; m_line = 0; m_first = 1;
      end else if (m_dot == DOTS - 1) begin
        m_dot = 0; m_first = 0;
        m_line = (m_line == LINES - 1) ? 0 : m_line + 1;
      end else begin
        m_dot++;
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    logic [7:0] es;
    #SAMPLE;
    if (rst_n && run_cmp) begin
      es = {1'b1, m_en, exp_coin(), 2'(exp_mode())};
      compared += 3;
      if (irq_pulse !== m_irq) begin
        mismatched++;
        $display("FAIL R3 irq_pulse at %0t: got %0b expected %0b", $time, irq_pulse, m_irq);
      end
      if (stat_rd !== es) begin
        mismatched++;
        $display("FAIL R9 stat_rd at %0t: got %h expected %h", $time, stat_rd, es);
      end
      if (int'(line_rd) != m_line) begin
        mismatched++;
        $display("FAIL R1 line_rd at %0t: got %0d expected %0d", $time, line_rd, m_line);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #SAMPLE;
  endtask

  task automatic wait_line_start(input int v);
    step();
    while (int'(line_rd) == v) step();
    while (int'(line_rd) != v) step();
  endtask

  // Writes one register and watches n samples after the write edge.
  task automatic write_watch(input bit is_stat, input logic [7:0] v, input int n,
                             output int n_irq, output int first_k, output logic [7:0] coin_h);
    @(negedge clk);
    wr_data = v;
    if (is_stat) wr_stat = 1'b1; else wr_lyc = 1'b1;
    n_irq = 0; first_k = 0; coin_h = 8'h00;
    for (int k = 1; k <= n; k++) begin
      step();
      if (irq_pulse) begin
        n_irq++;
        if (first_k == 0) first_k = k;
      end
      coin_h[k-1] = stat_rd[2];
      if (k == 1) begin
        @(negedge clk);
        wr_stat = 1'b0; wr_lyc = 1'b0;
      end
    end
  endtask

  task automatic count_frame(output int n);
    n = 0;
    wait_line_start(1);
    for (int k = 1; k <= FRAME; k++) begin
      step();
      if (irq_pulse) n++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int m3a, m3b, len1, n, fk;
    logic [7:0] ch;
    m3a = 0; m3b = 0; len1 = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    run_cmp = 1'b1;
    step();
    // R11 reset state
    check("R11 stat after reset", int'(stat_rd), 'h80);
    check("R11 line after reset", int'(line_rd), 0);
    check("R11 irq after reset", int'(irq_pulse), 0);

    // R2 longer transfer on first line, R1 line length
    @(negedge clk) lcd_on = 1'b1;
    step();
    while (line_rd == 8'd0) begin
      if (stat_rd[1:0] == 2'd3) m3a++;
      step();
    end
    while (line_rd == 8'd1) begin
      len1++;
      if (stat_rd[1:0] == 2'd3) m3b++;
      step();
    end
    check("R2 transfer dots first line", m3a, XFER + EXTRA);
    check("R2 transfer dots later line", m3b, XFER);
    check("R1 dots per line", len1, DOTS);

    // R4 only object-search source: extra request on line VST
    wait_line_start(5);
    write_watch(1'b1, 8'h20, 1, n, fk, ch);
    count_frame(n);
    check("R4 pulses per frame search only", n, VST + 1);

    // R3 shared line: vblank hides line 0 search request
    wait_line_start(5);
    write_watch(1'b1, 8'h30, 1, n, fk, ch);
    count_frame(n);
    check("R3 pulses per frame vblank+search", n, VST);

    wait_line_start(5);
    write_watch(1'b1, 8'h10, 1, n, fk, ch);
    count_frame(n);
    check("R3 pulses per frame vblank only", n, 1);

    // R5 compare latency
    write_watch(1'b1, 8'h00, 1, n, fk, ch);
    wait_line_start(3);
    write_watch(1'b0, 8'h03, LLAT + 2, n, fk, ch);
    check("R5 flag still old before latency", int'(ch[LLAT-1]), 0);
    check("R5 flag set after latency", int'(ch[LLAT]), 1);

    // R6 / R10 display off holds flag, resets line and phase
    @(negedge clk) lcd_on = 1'b0;
    step();
    check("R6 held flag and R10 phase", int'(stat_rd), 'h84);
    check("R10 line zero while off", int'(line_rd), 0);
    repeat (5) step();
    check("R6 flag still held", int'(stat_rd[2]), 1);
    write_watch(1'b1, 8'h08, 6, n, fk, ch);
    check("R10 no phase request while off", n, 0);
    write_watch(1'b1, 8'h48, 6, n, fk, ch);
    check("R7 request from held flag", n, 1);
    check("R8 late enable cycle", fk, ELAT + 2);

    // R7 status write during object search
    write_watch(1'b1, 8'h00, 4, n, fk, ch);
    write_watch(1'b0, 8'hFF, 4, n, fk, ch);
    @(negedge clk) lcd_on = 1'b1;
    wait_line_start(2);
    write_watch(1'b1, 8'h20, 4, n, fk, ch);
    check("R7 search write pulse count", n, 1);
    check("R7 search write pulse cycle", fk, 2);

    repeat (20) step();
    finish_run();
  end

endmodule